// File: doc/BRIEF.md
# Host-to-Local Byte Mailbox

This block gives an external host and a local processor a set of byte-wide mailboxes. Up to four channels are provided. In each channel, the host puts a byte into an inbound register that the local side drains. The local side puts a byte into an outbound register that the host collects. A status byte carries the handshake flags for both directions.

The host side is fed with host I/O cycles that have already been decoded: a write or read strobe, a 16-bit address and a data byte. Address bit 2 has a double role. On a write it tags the byte as a command (1) or as data (0), and that tag is kept in the status byte. On a read it selects the status byte (1) or the outbound byte (0). Every channel except the last has a fixed base address set by parameter. The last channel matches against a base address supplied on an input port, so local software can move it. The local side uses a synchronous register port with one cycle of read latency.

Top module: `hostmbx_top`

## Requirements
- R1: After reset, every inbound byte, outbound byte and status flag is 0, and both `hst_rdata` and `loc_rdata` read 0x00.
- R2: A host write that hits a channel with address bit 2 clear stores `hst_wdata` in that channel's inbound register, clears its command flag and sets its inbound-full flag.
- R3: A host write that hits a channel with address bit 2 set stores the byte, sets the command flag and sets the inbound-full flag.
- R4: A host read that hits a channel with address bit 2 clear returns that channel's outbound byte on `hst_rdata` one cycle after the strobe and clears its outbound-full flag. `hst_rdata` holds its value when no host read occurs.
- R5: A host read that hits a channel with address bit 2 set returns the status byte one cycle later and changes no state. The status byte has bit 0 = outbound-full, bit 1 = inbound-full, bit 3 = command flag, and all other bits 0.
- R6: A channel is hit when address bits 15..3 and 1..0 equal those of its base address, whatever the value of bit 2. Channels 0..NCH-2 use `FIXED_BASES` (defaults 0x0CA0, 0x0CA8, 0x0CB0). Channel NCH-1 uses `prog_base`, and a change to `prog_base` takes effect on the next cycle.
- R7: When several channels match one address, only the lowest-numbered one is hit.
- R8: A host read that hits no channel returns 0xFF and changes no state. A host write that hits no channel is ignored.
- R9: Local register codes are `loc_reg` 0 = inbound, 1 = outbound, 2 = status, and 3 reads 0x00. A local read returns the selected value on `loc_rdata` one cycle later, and a read of the inbound register clears inbound-full. A local write to the outbound register stores the byte and sets outbound-full. Local writes to the other codes are ignored.
- R10: When a set and a clear of the same flag fall in one cycle, the set wins. Read data in that cycle shows the values from before the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_base | input | AW | Base address of the last channel |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | AW | Host I/O address |
| hst_wdata | input | DW | Host write byte |
| hst_rdata | output | DW | Host read byte, valid one cycle after `hst_rd` |
| loc_sel | input | CW | Local channel select |
| loc_reg | input | 2 | Local register code |
| loc_wr | input | 1 | Local write enable |
| loc_rd | input | 1 | Local read enable |
| loc_wdata | input | DW | Local write byte |
| loc_rdata | output | DW | Local read byte, valid one cycle after `loc_rd` |

## Verification
Both read ports take their result on the rising edge that samples the strobe. The bench drives strobes on falling edges and compares each read byte on the next falling edge. Flags changed by a write or a read show up in a status read issued in the cycle right after. The directed checks therefore read status back one strobe later, through either port, and never in the same cycle. A behavioural model updated on every rising edge predicts both read bytes, and they are compared on every falling edge during directed and random traffic.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [1:0] LREG_IDR  = 2'd0;
  localparam logic [1:0] LREG_ODR  = 2'd1;
  localparam logic [1:0] LREG_STAT = 2'd2;

  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_CMD = 3;

  function automatic logic [7:0] stat_byte(input logic obf, input logic ibf, input logic cmd);
    logic [7:0] s;
    s = 8'h00;
    s[ST_OBF] = obf;
    s[ST_IBF] = ibf;
    s[ST_CMD] = cmd;
    return s;
  endfunction
endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec #(
  parameter int NCH = 4,
  parameter int AW = 16,
  parameter int SEL_BIT = 2,
  parameter logic [(NCH-1)*AW-1:0] FIXED_BASES = '0,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [AW-1:0]  addr,
  input  logic [AW-1:0]  prog_base,
  output logic [NCH-1:0] hit_oh,
  output logic           hit_any,
  output logic [CW-1:0]  hit_idx
);
  localparam logic [AW-1:0] CMP_MASK = ~(AW'(1) << SEL_BIT);

  logic [AW-1:0]  base_w [NCH];
  logic [NCH-1:0] raw;

  for (genvar g = 0; g < NCH; g++) begin : g_match
    if (g == NCH - 1) begin : g_prog
      assign base_w[g] = prog_base;
    end else begin : g_fixed
      assign base_w[g] = FIXED_BASES[g*AW +: AW];
    end
    assign raw[g] = ((addr ^ base_w[g]) & CMP_MASK) == '0;
  end

  always_comb begin
    hit_oh  = '0;
    hit_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (raw[i]) begin
        hit_oh    = '0;
        hit_oh[i] = 1'b1;
        hit_idx   = CW'(i);
      end
    end
  end

  assign hit_any = |raw;
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_wr,
  input  logic          h_cmd,
  input  logic [DW-1:0] h_data,
  input  logic          h_drd,
  input  logic          l_idr_rd,
  input  logic          l_odr_wr,
  input  logic [DW-1:0] l_data,
  output logic [DW-1:0] idr,
  output logic [DW-1:0] odr,
  output logic          ibf,
  output logic          obf,
  output logic          cmd
);
  logic ibf_d, obf_d, cmd_d;

  always_comb begin
    ibf_d = ibf;
    obf_d = obf;
    cmd_d = cmd;
    if (l_idr_rd) ibf_d = 1'b0;
    if (h_drd)    obf_d = 1'b0;
    if (h_wr) begin
      ibf_d = 1'b1;
      cmd_d = h_cmd;
    end
    if (l_odr_wr) obf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf <= 1'b0;
      obf <= 1'b0;
      cmd <= 1'b0;
    end else begin
      ibf <= ibf_d;
      obf <= obf_d;
      cmd <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idr <= '0;
    end else if (h_wr) begin
      idr <= h_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odr <= '0;
    end else if (l_odr_wr) begin
      odr <= l_data;
    end
  end
endmodule

// File: rtl/hostmbx_top.sv
module hostmbx_top
  import mbx_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SEL_BIT = 2,
  parameter logic [(NCH-1)*AW-1:0] FIXED_BASES = {16'h0CB0, 16'h0CA8, 16'h0CA0},
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] prog_base,
  input  logic          hst_wr,
  input  logic          hst_rd,
  input  logic [AW-1:0] hst_addr,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata,
  input  logic [CW-1:0] loc_sel,
  input  logic [1:0]    loc_reg,
  input  logic          loc_wr,
  input  logic          loc_rd,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata
);
  logic [NCH-1:0] hit_oh;
  logic           hit_any;
  logic [CW-1:0]  hit_idx;
  logic [NCH-1:0] ibf_q, obf_q, cmd_q;
  logic [DW-1:0]  idr_q [NCH];
  logic [DW-1:0]  odr_q [NCH];
  logic [NCH-1:0] loc_oh;
  logic           sel_ok;
  logic           h_is_stat;
  logic [DW-1:0]  hrd_d, lrd_d;

  assign h_is_stat = hst_addr[SEL_BIT];
  assign sel_ok    = {1'b0, loc_sel} < (CW+1)'(NCH);
  assign loc_oh    = sel_ok ? (NCH'(1) << loc_sel) : '0;

  mbx_addr_dec #(
    .NCH(NCH), .AW(AW), .SEL_BIT(SEL_BIT), .FIXED_BASES(FIXED_BASES)
  ) u_dec (
    .addr(hst_addr),
    .prog_base(prog_base),
    .hit_oh(hit_oh),
    .hit_any(hit_any),
    .hit_idx(hit_idx)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mbx_chan #(.DW(DW)) u_ch (
      .clk(clk),
      .rst_n(rst_n),
      .h_wr(hst_wr & hit_oh[g]),
      .h_cmd(h_is_stat),
      .h_data(hst_wdata),
      .h_drd(hst_rd & hit_oh[g] & ~h_is_stat),
      .l_idr_rd(loc_rd & loc_oh[g] & (loc_reg == LREG_IDR)),
      .l_odr_wr(loc_wr & loc_oh[g] & (loc_reg == LREG_ODR)),
      .l_data(loc_wdata),
      .idr(idr_q[g]),
      .odr(odr_q[g]),
      .ibf(ibf_q[g]),
      .obf(obf_q[g]),
      .cmd(cmd_q[g])
    );
  end

  always_comb begin
    if (!hit_any)
      hrd_d = '1;
    else if (h_is_stat)
      hrd_d = DW'(stat_byte(obf_q[hit_idx], ibf_q[hit_idx], cmd_q[hit_idx]));
    else
      hrd_d = odr_q[hit_idx];
  end

  always_comb begin
    lrd_d = '0;
    if (sel_ok) begin
      case (loc_reg)
        LREG_IDR:  lrd_d = idr_q[loc_sel];
        LREG_ODR:  lrd_d = odr_q[loc_sel];
        LREG_STAT: lrd_d = DW'(stat_byte(obf_q[loc_sel], ibf_q[loc_sel], cmd_q[loc_sel]));
        default:   lrd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hst_rdata <= '0;
    end else if (hst_rd) begin
      hst_rdata <= hrd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_rdata <= '0;
    end else if (loc_rd) begin
      loc_rdata <= lrd_d;
    end
  end
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int NCH = 4,
  parameter int DW = 8,
  parameter int CW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hst_wr,
  input logic           hst_rd,
  input logic [DW-1:0]  hst_rdata,
  input logic           loc_wr,
  input logic           loc_rd,
  input logic [CW-1:0]  loc_sel,
  input logic [1:0]     loc_reg,
  input logic [NCH-1:0] hit_oh,
  input logic [NCH-1:0] ibf_q,
  input logic [NCH-1:0] obf_q
);
  logic [NCH-1:0] sel_oh;
  assign sel_oh = NCH'(1) << loc_sel;

  p_single_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_oh));

  p_write_sets_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && |hit_oh) |=> |(ibf_q & $past(hit_oh)));

  p_miss_reads_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && !(|hit_oh)) |=> (hst_rdata == '1));

  p_rdata_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hst_rd |=> $stable(hst_rdata));

  p_odr_write_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr && loc_reg == 2'd1 && |sel_oh) |=> |(obf_q & $past(sel_oh)));

  p_ibf_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hst_wr && !(loc_rd && loc_reg == 2'd0)) |=> $stable(ibf_q));
endmodule

bind hostmbx_top mbx_chk #(.NCH(NCH), .DW(DW), .CW(CW)) i_chk (
  .clk(clk),
  .rst_n(rst_n),
  .hst_wr(hst_wr),
  .hst_rd(hst_rd),
  .hst_rdata(hst_rdata),
  .loc_wr(loc_wr),
  .loc_rd(loc_rd),
  .loc_sel(loc_sel),
  .loc_reg(loc_reg),
  .hit_oh(hit_oh),
  .ibf_q(ibf_q),
  .obf_q(obf_q)
);

// File: tb/test_hostmbx_top.sv
module test_hostmbx_top;
  localparam logic [15:0] FB0 = 16'h0CA0;
  localparam logic [15:0] FB1 = 16'h0CA8;
  localparam logic [15:0] FB2 = 16'h0CB0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] prog_base = 16'h0CC0;
  logic        hst_wr = 1'b0, hst_rd = 1'b0;
  logic [15:0] hst_addr = 16'h0;
  logic [7:0]  hst_wdata = 8'h0;
  logic [7:0]  hst_rdata;
  logic [1:0]  loc_sel = 2'd0, loc_reg = 2'd0;
  logic        loc_wr = 1'b0, loc_rd = 1'b0;
  logic [7:0]  loc_wdata = 8'h0;
  logic [7:0]  loc_rdata;

  int    total = 0, bad = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  hostmbx_top i_hostmbx_top (
    .clk(clk), .rst_n(rst_n), .prog_base(prog_base),
    .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .loc_sel(loc_sel), .loc_reg(loc_reg), .loc_wr(loc_wr),
    .loc_rd(loc_rd), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
  );

  // behavioural reference
  logic [7:0] m_idr [4];
  logic [7:0] m_odr [4];
  bit         m_ibf [4];
  bit         m_obf [4];
  bit         m_cmd [4];
  logic [7:0] e_h, e_l;

  function automatic int find_ch(input logic [15:0] a);
    for (int i = 0; i < 4; i++) begin
      logic [15:0] b;
      b = (i == 0) ? FB0 : (i == 1) ? FB1 : (i == 2) ? FB2 : prog_base;
      if (((a ^ b) & 16'hFFFB) == 16'h0) return i;
    end
    return -1;
  endfunction

  function automatic logic [7:0] m_stat(input int c);
    return {4'b0, m_cmd[c], 1'b0, m_ibf[c], m_obf[c]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_idr[i] = 8'h00; m_odr[i] = 8'h00;
        m_ibf[i] = 0; m_obf[i] = 0; m_cmd[i] = 0;
      end
      e_h = 8'h00; e_l = 8'h00;
    end else begin
      int hc;
      hc = find_ch(hst_addr);
      if (hst_rd)
        e_h = (hc < 0) ? 8'hFF : (hst_addr[2] ? m_stat(hc) : m_odr[hc]);
      if (loc_rd)
        case (loc_reg)
          2'd0: e_l = m_idr[loc_sel];
          2'd1: e_l = m_odr[loc_sel];
          2'd2: e_l = m_stat(int'(loc_sel));
          default: e_l = 8'h00;
        endcase
      if (hst_rd && hc >= 0 && !hst_addr[2]) m_obf[hc] = 0;
      if (loc_rd && loc_reg == 2'd0) m_ibf[loc_sel] = 0;
      if (hst_wr && hc >= 0) begin
        m_idr[hc] = hst_wdata; m_cmd[hc] = hst_addr[2]; m_ibf[hc] = 1;
      end
      if (loc_wr && loc_reg == 2'd1) begin
        m_odr[loc_sel] = loc_wdata; m_obf[loc_sel] = 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_tag, " host port vs model"}, hst_rdata, e_h);
      chk({cur_tag, " local port vs model"}, loc_rdata, e_l);
    end
  end

  task automatic h_write(input logic [15:0] a, input logic [7:0] d, input string t);
    cur_tag = t;
    @(negedge clk); hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
    @(negedge clk); hst_wr = 1'b0;
  endtask

  task automatic h_read(input logic [15:0] a, input logic [7:0] exp, input string t);
    cur_tag = t;
    @(negedge clk); hst_addr = a; hst_rd = 1'b1;
    @(negedge clk); hst_rd = 1'b0;
    chk({t, " host read"}, hst_rdata, exp);
  endtask

  task automatic l_write(input logic [1:0] s, input logic [1:0] r, input logic [7:0] d, input string t);
    cur_tag = t;
    @(negedge clk); loc_sel = s; loc_reg = r; loc_wdata = d; loc_wr = 1'b1;
    @(negedge clk); loc_wr = 1'b0;
  endtask

  task automatic l_read(input logic [1:0] s, input logic [1:0] r, input logic [7:0] exp, input string t);
    cur_tag = t;
    @(negedge clk); loc_sel = s; loc_reg = r; loc_rd = 1'b1;
    @(negedge clk); loc_rd = 1'b0;
    chk({t, " local read"}, loc_rdata, exp);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog (all requirements) act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset host", hst_rdata, 8'h00);
    chk("R1 reset local", loc_rdata, 8'h00);
    rst_n = 1'b1;
    h_read(16'h0CA4, 8'h00, "R1");
    h_read(16'h0CA0, 8'h00, "R1");
    l_read(2'd2, 2'd0, 8'h00, "R1");

    h_write(16'h0CA0, 8'h5A, "R2");
    h_read(16'h0CA4, 8'h02, "R2");
    l_read(2'd0, 2'd0, 8'h5A, "R9");
    h_read(16'h0CA4, 8'h00, "R9");

    h_write(16'h0CAC, 8'hC3, "R3");
    l_read(2'd1, 2'd2, 8'h0A, "R3");
    h_read(16'h0CAC, 8'h0A, "R5");
    l_read(2'd1, 2'd2, 8'h0A, "R5");

    h_write(16'h0CA9, 8'h13, "R8");
    h_read(16'h0CA9, 8'hFF, "R8");
    l_read(2'd1, 2'd0, 8'hC3, "R8");

    l_write(2'd2, 2'd1, 8'h77, "R9");
    h_read(16'h0CB4, 8'h01, "R9");
    h_read(16'h0CB0, 8'h77, "R4");
    h_read(16'h0CB4, 8'h00, "R4");
    h_read(16'h0CB0, 8'h77, "R4");

    h_write(16'h0CC4, 8'h11, "R6");
    l_read(2'd3, 2'd2, 8'h0A, "R6");
    @(negedge clk); prog_base = 16'h03F1;
    h_write(16'h03F5, 8'h22, "R6");
    l_read(2'd3, 2'd0, 8'h22, "R6");
    h_write(16'h0CC0, 8'h33, "R6");
    l_read(2'd3, 2'd2, 8'h08, "R6");

    @(negedge clk); prog_base = FB1;
    h_write(16'h0CA8, 8'h44, "R7");
    l_read(2'd1, 2'd0, 8'h44, "R7");
    l_read(2'd3, 2'd0, 8'h22, "R7");
    l_write(2'd3, 2'd1, 8'h99, "R7");
    h_read(16'h0CA8, 8'h00, "R7");

    l_write(2'd0, 2'd0, 8'hEE, "R9");
    l_read(2'd0, 2'd0, 8'h5A, "R9");
    l_read(2'd0, 2'd3, 8'h00, "R9");

    cur_tag = "R10";
    @(negedge clk);
    hst_addr = 16'h0CA0; hst_wdata = 8'h66; hst_wr = 1'b1;
    loc_sel = 2'd0; loc_reg = 2'd0; loc_rd = 1'b1;
    @(negedge clk); hst_wr = 1'b0; loc_rd = 1'b0;
    chk("R10 local old byte", loc_rdata, 8'h5A);
    h_read(16'h0CA4, 8'h02, "R10");
    @(negedge clk);
    hst_addr = 16'h0CB0; hst_rd = 1'b1;
    loc_sel = 2'd2; loc_reg = 2'd1; loc_wdata = 8'h3C; loc_wr = 1'b1;
    @(negedge clk); hst_rd = 1'b0; loc_wr = 1'b0;
    chk("R10 host old byte", hst_rdata, 8'h77);
    h_read(16'h0CB4, 8'h01, "R10");
    h_read(16'h0CB0, 8'h3C, "R10");

    @(negedge clk); prog_base = 16'h0CC0;
    cur_tag = "R2";
    for (int k = 0; k < 3000; k++) begin
      int pick;
      @(negedge clk);
      pick = int'($urandom % 5);
      case (pick)
        0: hst_addr = FB0;
        1: hst_addr = FB1;
        2: hst_addr = FB2;
        3: hst_addr = prog_base;
        default: hst_addr = 16'($urandom);
      endcase
      if (pick < 4 && ($urandom % 2) == 1) hst_addr = hst_addr | 16'h0004;
      hst_wdata = 8'($urandom);
      hst_wr = ($urandom % 4) == 0;
      hst_rd = !hst_wr && (($urandom % 3) == 0);
      loc_sel = 2'($urandom);
      loc_reg = 2'($urandom);
      loc_wdata = 8'($urandom);
      loc_rd = ($urandom % 3) == 0;
      loc_wr = ($urandom % 3) == 0;
    end
    @(negedge clk);
    hst_wr = 1'b0; hst_rd = 1'b0; loc_wr = 1'b0; loc_rd = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule